// File: doc/BRIEF.md
# Prescaled PWM Channel with Staged Updates

This block drives one pulse-width-modulated output. A reloading prescaler divides the clock by one of eight powers of two. The divided ticks advance a period counter that runs from 0 up to the period count minus one. The output takes a programmable active level while the counter is below the duty count. For the rest of the period it takes a programmable inactive level. Each level is a 2-bit code.

Software first writes a duty word and then a configuration word. The configuration word carries the period, the divider code and the two level codes. Both words go into staging registers. The configuration write arms an update. The armed update copies all staged fields into the working registers together, either at the next period wrap or at the next clock edge if the channel is idle. A running waveform therefore never mixes old and new settings.

The channel is controlled by a two-state machine:
- IDLE: the channel is disabled. The counters are held at zero and the output shows the inactive level.
- RUN: the channel is counting.

There are two transitions:
- START (IDLE to RUN): taken when `chan_en` is high at a clock edge.
- STOP (RUN to IDLE): taken when `chan_en` is low at a clock edge.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the channel is in IDLE, all working fields are zero, and `pwm_out` is low.
- R2: In RUN the period counter steps 0 to P-1 and then wraps, where P is the working period (a period of 0 behaves as 1). `pwm_out` shows the active level while the count is below the working duty and the inactive level otherwise. A duty of 0 gives a fully inactive output, and a duty of P or more gives a fully active output.
- R3: The divider code is `cfg_wdata[22:20]`. Codes 0 to 7 make each count last 1, 2, 4, 8, 16, 64, 256 or 1024 clocks.
- R4: The active-level code is `cfg_wdata[17:16]` and the inactive-level code is `cfg_wdata[19:18]`. Code 3 drives `pwm_out` high. Codes 2, 1 and 0 drive it low.
- R5: The duty count is `duty_wdata[31:16]` and the period count is `cfg_wdata[15:0]`.
- R6: A duty write alone only stages a value and changes nothing at the output. Only a configuration write arms an update.
- R7: While the channel runs, an armed update loads at the wrap edge that ends the current period. The old settings hold up to and including the last count of that period. An update armed on the wrap edge itself waits for the following wrap.
- R8: While the channel is in IDLE, an armed update loads on the next clock edge.
- R9: In IDLE the counter and prescaler are held at zero and `pwm_out` shows the working inactive level.
- R10: The START transition begins a fresh period at count 0 with the prescaler phase cleared, whatever state the channel was in when it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| duty_we | input | 1 | Duty word write strobe |
| duty_wdata | input | 32 | Duty word; bits 31:16 hold the duty count |
| cfg_we | input | 1 | Configuration word write strobe; arms the update |
| cfg_wdata | input | 32 | Period 15:0, active code 17:16, inactive code 19:18, divider 22:20 |
| pwm_out | output | 1 | PWM output level |

## Verification
`pwm_out` is decoded combinationally from registered state. If `chan_en` is first sampled high at edge E0, the value for count k appears in the cycle that follows edge E0+k. The bench therefore drives inputs on the falling edge and samples there. Sample j after enabling is compared with the level for count (j >> shift) mod P. A strobe raised right after sample j is captured at the end of cycle j. The staging tests rely on this to place the arming write before the wrap edge, and also exactly on it, so each switch to new settings is expected on a known cycle. In IDLE a configuration write is expected to change the inactive level one clock after its strobe is captured.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 3;
    localparam int LVL_W  = 2;
    localparam int PRE_W  = 10;
    localparam int SH_W   = 4;

    typedef enum logic [0:0] {CH_IDLE = 1'b0, CH_RUN = 1'b1} ch_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
        logic [DIV_W-1:0] div;
        logic [LVL_W-1:0] act;
        logic [LVL_W-1:0] inact;
    } chan_cfg_t;

    // Divider code to right-shift amount (non-uniform above code 4)
    function automatic logic [SH_W-1:0] div_shift(input logic [DIV_W-1:0] code);
        logic [SH_W-1:0] s;
        unique case (code)
            3'd5:    s = 4'd6;
            3'd6:    s = 4'd8;
            3'd7:    s = 4'd10;
            default: s = {1'b0, code};
        endcase
        return s;
    endfunction

    // Only code 3 drives high
    function automatic logic level_drive(input logic [LVL_W-1:0] code);
        return (code == 2'b11);
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_chan_pkg::*;
#(
    parameter int P_W = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [P_W-1:0] pre_cnt;
    logic [P_W:0]   span;
    logic [P_W-1:0] limit;

    always_comb begin
        span  = (P_W+1)'(1) << div_shift(div);
        limit = P_W'(span - 1'b1);
    end

    assign tick = run && (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (!run || tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (pre_cnt <= limit)); // R3
    AST_PRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0)); // R9
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_val,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] period_val,
    input  logic [DIV_W-1:0] div_val,
    input  logic [LVL_W-1:0] act_val,
    input  logic [LVL_W-1:0] inact_val,
    input  logic             boundary,
    output chan_cfg_t        work
);
    chan_cfg_t stage;
    logic      pending;
    logic      load;

    assign load = pending && boundary;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            if (duty_wr)
                stage.duty <= duty_val;
            if (cfg_wr) begin
                stage.period <= period_val;
                stage.div    <= div_val;
                stage.act    <= act_val;
                stage.inact  <= inact_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (cfg_wr)
            pending <= 1'b1;
        else if (load)
            pending <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            work <= '0;
        else if (load)
            work <= stage;
    end

    AST_WORK_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(work) |-> $past(pending && boundary)); // R7
    AST_CFG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> pending); // R6
    AST_DUTY_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_wr && !cfg_wr && !pending) |=> !pending); // R6
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_chan_pkg::*;
#(
    parameter int C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           tick,
    input  logic [C_W-1:0] period,
    output ch_state_e      state,
    output logic [C_W-1:0] cnt,
    output logic           wrap
);
    ch_state_e      state_nx;
    logic [C_W-1:0] last;

    assign last = (period == '0) ? '0 : period - 1'b1;
    assign wrap = (state == CH_RUN) && tick && (cnt >= last);

    always_comb begin
        unique case (state)
            CH_IDLE: state_nx = en ? CH_RUN : CH_IDLE;   // START
            CH_RUN:  state_nx = en ? CH_RUN : CH_IDLE;   // STOP
            default: state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CH_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (state != CH_RUN || !en)
            cnt <= '0;
        else if (tick)
            cnt <= wrap ? '0 : cnt + 1'b1;
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_RUN) |-> (cnt <= last)); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE) |-> (cnt == '0)); // R9
    AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE && en) |=> (state == CH_RUN && cnt == '0)); // R10
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
    import pwm_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chan_en,
    input  logic        duty_we,
    input  logic [31:0] duty_wdata,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic        pwm_out
);
    chan_cfg_t        work;
    ch_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             tick;
    logic             run;
    logic             boundary;
    logic             unused_bits;

    assign unused_bits = ^{duty_wdata[15:0], cfg_wdata[31:23]};
    assign run         = (state == CH_RUN) && chan_en;
    assign boundary    = (state == CH_IDLE) || wrap;

    pwm_shadow_regs u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty_wr    (duty_we),
        .duty_val   (duty_wdata[31:16]),
        .cfg_wr     (cfg_we),
        .period_val (cfg_wdata[15:0]),
        .div_val    (cfg_wdata[22:20]),
        .act_val    (cfg_wdata[17:16]),
        .inact_val  (cfg_wdata[19:18]),
        .boundary   (boundary),
        .work       (work)
    );

    pwm_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (work.div),
        .tick  (tick)
    );

    pwm_period_ctr u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (chan_en),
        .tick   (tick),
        .period (work.period),
        .state  (state),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    always_comb begin
        unique case (state)
            CH_RUN:  pwm_out = (cnt < work.duty) ? level_drive(work.act)
                                                 : level_drive(work.inact);
            default: pwm_out = level_drive(work.inact);
        endcase
    end

    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IDLE) |-> (pwm_out == (work.inact == 2'b11))); // R9
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (work.duty == '0) |-> (pwm_out == (work.inact == 2'b11))); // R2
    AST_LOW_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (work.act != 2'b11 && work.inact != 2'b11) |-> !pwm_out); // R4
endmodule

// File: tb/pwm_shadow_chan_test.sv
module pwm_shadow_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        duty_we = 1'b0;
    logic [31:0] duty_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_shadow_chan uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .duty_we(duty_we), .duty_wdata(duty_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pwm_out(pwm_out)
    );

    function automatic int shift_of(input int code);
        if (code < 5) return code;
        if (code == 5) return 6;
        if (code == 6) return 8;
        return 10;
    endfunction

    function automatic logic model(input int j, input int duty, input int period,
                                   input int div, input int act, input int inact);
        int p = (period == 0) ? 1 : period;
        int c = (j >> shift_of(div)) % p;
        return (c < duty) ? (act == 3) : (inact == 3);
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: %s got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic sample(input int j, input int duty, input int period, input int div,
                          input int act, input int inact, input string req);
        @(negedge clk);
        check(pwm_out, model(j, duty, period, div, act, inact), req, $sformatf("cycle %0d", j));
    endtask

    task automatic expect_run(input int n, input int j0, input int duty, input int period,
                              input int div, input int act, input int inact, input string req);
        for (int j = j0; j < j0 + n; j++)
            sample(j, duty, period, div, act, inact, req);
    endtask

    function automatic logic [31:0] cfg_word(input int period, input int div,
                                             input int act, input int inact);
        return {9'b0, 3'(div), 2'(inact), 2'(act), 16'(period)};
    endfunction

    task automatic write_duty(input int duty);
        duty_we = 1'b1; duty_wdata = {16'(duty), 16'hA5A5};
        @(negedge clk);
        duty_we = 1'b0;
    endtask

    task automatic write_cfg(input int period, input int div, input int act, input int inact);
        cfg_we = 1'b1; cfg_wdata = cfg_word(period, div, act, inact);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // configure while idle and start in the same edge as the load
    task automatic start(input int duty, input int period, input int div,
                         input int act, input int inact);
        chan_en = 1'b0;
        @(negedge clk);
        write_duty(duty);
        write_cfg(period, div, act, inact);
        chan_en = 1'b1;
    endtask

    task automatic stop();
        chan_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pwm_out, 1'b0, "R1", "reset output");
        end
    endtask

    task automatic t_normal();
        start(3, 8, 0, 3, 2);
        expect_run(24, 0, 3, 8, 0, 3, 2, "R2 R5");
        stop();
    endtask

    task automatic t_inverse();
        start(2, 5, 0, 2, 3);
        expect_run(15, 0, 2, 5, 0, 2, 3, "R4");
        stop();
    endtask

    task automatic t_edges();
        start(0, 4, 0, 3, 2);
        expect_run(8, 0, 0, 4, 0, 3, 2, "R2 zero duty");
        stop();
        start(9, 6, 0, 3, 2);
        expect_run(12, 0, 9, 6, 0, 3, 2, "R2 full duty");
        stop();
        start(1, 0, 0, 3, 2);
        expect_run(4, 0, 1, 0, 0, 3, 2, "R2 zero period");
        stop();
    endtask

    task automatic t_div();
        start(1, 3, 1, 3, 2);
        expect_run(12, 0, 1, 3, 1, 3, 2, "R3 div2");
        stop();
        start(1, 2, 5, 3, 2);
        expect_run(260, 0, 1, 2, 5, 3, 2, "R3 div64");
        stop();
        start(1, 2, 7, 3, 2);
        expect_run(4100, 0, 1, 2, 7, 3, 2, "R3 div1024");
        stop();
    endtask

    task automatic t_codes();
        start(2, 4, 0, 1, 0);
        expect_run(8, 0, 2, 4, 0, 1, 0, "R4 codes 1/0");
        stop();
        start(2, 4, 0, 0, 3);
        expect_run(8, 0, 2, 4, 0, 0, 3, "R4 code 0 active");
        stop();
    endtask

    task automatic t_shadow();
        start(2, 8, 0, 3, 2);
        expect_run(4, 0, 2, 8, 0, 3, 2, "R7");
        duty_we = 1'b1; duty_wdata = {16'd6, 16'h0};
        sample(4, 2, 8, 0, 3, 2, "R7 old after duty");
        duty_we = 1'b0;
        cfg_we = 1'b1; cfg_wdata = cfg_word(10, 0, 3, 2);
        sample(5, 2, 8, 0, 3, 2, "R7 old after cfg");
        cfg_we = 1'b0;
        expect_run(2, 6, 2, 8, 0, 3, 2, "R7 old to wrap");
        expect_run(20, 0, 6, 10, 0, 3, 2, "R7 new period");
        stop();
    endtask

    task automatic t_duty_only();
        start(2, 4, 0, 3, 2);
        expect_run(2, 0, 2, 4, 0, 3, 2, "R6");
        duty_we = 1'b1; duty_wdata = {16'd3, 16'h0};
        expect_run(10, 2, 2, 4, 0, 3, 2, "R6 duty alone");
        duty_we = 1'b0;
        cfg_we = 1'b1; cfg_wdata = cfg_word(4, 0, 3, 2);
        sample(12, 2, 4, 0, 3, 2, "R7 armed on wrap edge");
        cfg_we = 1'b0;
        expect_run(3, 13, 2, 4, 0, 3, 2, "R7 waits next wrap");
        expect_run(8, 16, 3, 4, 0, 3, 2, "R7 applied");
        stop();
    endtask

    task automatic t_restart();
        start(2, 5, 1, 3, 2);
        expect_run(7, 0, 2, 5, 1, 3, 2, "R10");
        chan_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pwm_out, 1'b0, "R9", "disabled inactive");
        end
        chan_en = 1'b1;
        expect_run(12, 0, 2, 5, 1, 3, 2, "R10 restart");
        stop();
    endtask

    task automatic t_idle_load();
        chan_en = 1'b0;
        @(negedge clk);
        check(pwm_out, 1'b0, "R9", "idle before load");
        write_cfg(4, 0, 2, 3);
        @(negedge clk);
        check(pwm_out, 1'b1, "R8", "idle immediate load");
        @(negedge clk);
        check(pwm_out, 1'b1, "R9", "idle inverse inactive");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_inverse();
        t_edges();
        t_div();
        t_codes();
        t_shadow();
        t_duty_only();
        t_restart();
        t_idle_load();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule